// File: doc/BRIEF.md
# Per-Processor Prefix Address Translator

This block sits between the real-address stage and the memory port of a single processor. Each processor owns a 12-bit page relocation value. The block uses that value to exchange two 4 KiB pages. A real access to page zero is sent to the processor's own relocation page, so every processor gets a private low page. A real access to the relocation page is sent back to absolute page zero, so the shared block stays reachable. Any other page passes through unchanged. The byte offset inside the page is never touched.

Real addresses narrower than the absolute width are zero-extended on the left before the page is compared. Each address arrives with a valid strobe. The translated absolute address appears one clock later with its own valid flag. The relocation value is written through a write-enable port.

The translation is sorted into three named cases:
- `XC_PASS`: the page is not swapped.
- `XC_FORWARD`: page zero is moved to the relocation page.
- `XC_REVERSE`: the relocation page is moved back to page zero.

The case is chosen in every cycle that carries a valid address. The block has no other sequencing.

Top module: `prefix_xlate`

## Requirements
- R1: After reset, `abs_vld` is 0, `abs_addr` is 0 and the relocation value is 0.
- R2: A valid address whose upper 12 bits (absolute bits 23:12) are all zero is output with those bits replaced by the relocation value (XC_FORWARD).
- R3: A valid address whose upper 12 bits equal a nonzero relocation value is output with those bits forced to zero (XC_REVERSE).
- R4: A valid address whose upper 12 bits are neither zero nor equal to the relocation value is output unchanged (XC_PASS).
- R5: Bits 11:0 of `abs_addr` always equal bits 11:0 of the real address that produced it.
- R6: `abs_vld` is high exactly in the cycle after a cycle with `ra_vld` high, and `abs_addr` is updated in that same cycle.
- R7: A write on `pfx_we` takes effect from the next cycle. An address presented in the same cycle as the write is translated with the old relocation value.
- R8: With a relocation value of zero, every address is output unchanged.
- R9: While `ra_vld` is low, `abs_addr` holds its last value.
- R10: When the parameter `RA_W` is less than 24, the real address is zero-extended to 24 bits before the rules of R2 to R4 are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pfx_we | input | 1 | Write strobe for the relocation value |
| pfx_din | input | 12 | New relocation page number |
| ra_vld | input | 1 | Real address valid |
| ra | input | RA_W (24) | Real address |
| abs_vld | output | 1 | Absolute address valid, one cycle after `ra_vld` |
| abs_addr | output | 24 | Translated absolute address |

## Verification
A relocation write and a valid address can occur in the same cycle. The write must not change the translation of the address that arrives with it. The bench provokes this by writing a new value while presenting an address on the new relocation page, and again while presenting page zero. It expects the old value to govern both translations and the new value to govern the address in the following cycle. The bench's behavioural model applies the write only after it has translated the address of that cycle. The model's output is compared with the design in every clock, both for the full-width instance and for a 16-bit instance that exercises zero-extension.

// File: rtl/prefix_pkg.sv
package prefix_pkg;

    typedef enum logic [1:0] {
        XC_PASS    = 2'd0,
        XC_FORWARD = 2'd1,
        XC_REVERSE = 2'd2
    } xcase_e;

endpackage

// File: rtl/prefix_reg.sv
module prefix_reg #(
    parameter int PAGE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [PAGE_W-1:0] din,
    output logic [PAGE_W-1:0] q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (we) begin
            q <= din;
        end
    end

endmodule

// File: rtl/prefix_classify.sv
module prefix_classify
    import prefix_pkg::*;
#(
    parameter int PAGE_W = 12
) (
    input  logic [PAGE_W-1:0] page_in,
    input  logic [PAGE_W-1:0] pfx,
    output xcase_e            kind,
    output logic [PAGE_W-1:0] page_out
);

    logic page_zero;
    logic page_hit;

    assign page_zero = (page_in == '0);
    assign page_hit  = (page_in == pfx);

    // Page zero takes priority: with a zero relocation value both
    // tests match and either result is zero, so the output is steady.
    always_comb begin
        if (page_zero) begin
            kind = XC_FORWARD;
        end else if (page_hit) begin
            kind = XC_REVERSE;
        end else begin
            kind = XC_PASS;
        end
    end

    always_comb begin
        unique case (kind)
            XC_FORWARD: page_out = pfx;
            XC_REVERSE: page_out = '0;
            XC_PASS:    page_out = page_in;
            default:    page_out = page_in;
        endcase
    end

endmodule

// File: rtl/prefix_xlate.sv
module prefix_xlate
    import prefix_pkg::*;
#(
    parameter int RA_W  = 24,
    parameter int ABS_W = 24,
    parameter int OFF_W = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     pfx_we,
    input  logic [ABS_W-OFF_W-1:0]   pfx_din,
    input  logic                     ra_vld,
    input  logic [RA_W-1:0]          ra,
    output logic                     abs_vld,
    output logic [ABS_W-1:0]         abs_addr
);

    localparam int PAGE_W = ABS_W - OFF_W;

    logic [ABS_W-1:0]  ra_ext;
    logic [PAGE_W-1:0] pfx_q;
    logic [PAGE_W-1:0] page_new;
    xcase_e            kind;

    generate
        if (RA_W < ABS_W) begin : g_zext
            assign ra_ext = {{(ABS_W-RA_W){1'b0}}, ra};
        end else begin : g_full
            assign ra_ext = ra[ABS_W-1:0];
        end
    endgenerate

    prefix_reg #(.PAGE_W(PAGE_W)) u_pfx (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (pfx_we),
        .din   (pfx_din),
        .q     (pfx_q)
    );

    prefix_classify #(.PAGE_W(PAGE_W)) u_cls (
        .page_in  (ra_ext[ABS_W-1:OFF_W]),
        .pfx      (pfx_q),
        .kind     (kind),
        .page_out (page_new)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            abs_vld  <= 1'b0;
            abs_addr <= '0;
        end else begin
            abs_vld <= ra_vld;
            if (ra_vld) begin
                abs_addr <= {page_new, ra_ext[OFF_W-1:0]};
            end
        end
    end

endmodule

// File: rtl/prefix_xlate_chk.sv
module prefix_xlate_chk #(
    parameter int ABS_W = 24,
    parameter int OFF_W = 12
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   pfx_we,
    input logic [ABS_W-OFF_W-1:0] pfx_din,
    input logic [ABS_W-OFF_W-1:0] pfx,
    input logic                   ra_vld,
    input logic [ABS_W-1:0]       ra_ext,
    input logic                   abs_vld,
    input logic [ABS_W-1:0]       abs_addr
);

    a_r6_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
        ra_vld |=> abs_vld);
    a_r6_vld_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !ra_vld |=> !abs_vld);
    a_r5_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        ra_vld |=> abs_addr[OFF_W-1:0] == $past(ra_ext[OFF_W-1:0]));
    a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !ra_vld |=> $stable(abs_addr));
    a_r2_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_vld && ra_ext[ABS_W-1:OFF_W] == '0)
        |=> abs_addr[ABS_W-1:OFF_W] == $past(pfx));
    a_r3_reverse: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_vld && pfx != '0 && ra_ext[ABS_W-1:OFF_W] == pfx)
        |=> abs_addr[ABS_W-1:OFF_W] == '0);
    a_r4_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_vld && ra_ext[ABS_W-1:OFF_W] != '0 && ra_ext[ABS_W-1:OFF_W] != pfx)
        |=> abs_addr == $past(ra_ext));
    a_r7_pfx_load: assert property (@(posedge clk) disable iff (!rst_n)
        pfx_we |=> pfx == $past(pfx_din));

endmodule

bind prefix_xlate prefix_xlate_chk #(.ABS_W(ABS_W), .OFF_W(OFF_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pfx_we   (pfx_we),
    .pfx_din  (pfx_din),
    .pfx      (pfx_q),
    .ra_vld   (ra_vld),
    .ra_ext   (ra_ext),
    .abs_vld  (abs_vld),
    .abs_addr (abs_addr)
);

// File: tb/test_prefix_xlate.sv
module test_prefix_xlate;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pfx_we = 1'b0;
    logic [11:0] pfx_din = '0;
    logic        ra_vld = 1'b0;
    logic [23:0] ra = '0;
    logic        abs_vld, abs_vld_n;
    logic [23:0] abs_addr, abs_addr_n;

    int    n_vec = 0;
    int    n_bad = 0;
    bit    finished = 1'b0;
    string cur_tag = "R1";

    always #2.5 clk = ~clk;

    prefix_xlate i_prefix_xlate (
        .clk(clk), .rst_n(rst_n), .pfx_we(pfx_we), .pfx_din(pfx_din),
        .ra_vld(ra_vld), .ra(ra), .abs_vld(abs_vld), .abs_addr(abs_addr)
    );

    prefix_xlate #(.RA_W(16)) i_prefix_xlate_narrow (
        .clk(clk), .rst_n(rst_n), .pfx_we(pfx_we), .pfx_din(pfx_din),
        .ra_vld(ra_vld), .ra(ra[15:0]), .abs_vld(abs_vld_n), .abs_addr(abs_addr_n)
    );

    function automatic logic [23:0] ref_map(input logic [23:0] a, input logic [11:0] p);
        int pg;
        pg = int'(a[23:12]);
        if (pg == 0)             pg = int'(p);
        else if (pg == int'(p))  pg = 0;
        return {pg[11:0], a[11:0]};
    endfunction

    // behavioural reference
    logic [11:0] m_pfx;
    logic        m_vld;
    logic [23:0] m_addr, m_addr_n;
    string       m_tag;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pfx    <= '0;
            m_vld    <= 1'b0;
            m_addr   <= '0;
            m_addr_n <= '0;
            m_tag    <= "R1";
        end else begin
            m_vld <= ra_vld;
            if (ra_vld) begin
                m_addr   <= ref_map(ra, m_pfx);
                m_addr_n <= ref_map({8'h00, ra[15:0]}, m_pfx);
            end
            if (pfx_we) m_pfx <= pfx_din;
            m_tag <= cur_tag;
        end
    end

    always @(negedge clk) begin
        if (!finished) begin
            n_vec++;
            if (abs_vld !== m_vld || abs_addr !== m_addr) begin
                n_bad++;
                $display("FAIL %s (R6/R5): got vld=%0b addr=%06h expected vld=%0b addr=%06h",
                         m_tag, abs_vld, abs_addr, m_vld, m_addr);
            end
            if (abs_vld_n !== m_vld || abs_addr_n !== m_addr_n) begin
                n_bad++;
                $display("FAIL R10 (%s): narrow got vld=%0b addr=%06h expected vld=%0b addr=%06h",
                         m_tag, abs_vld_n, abs_addr_n, m_vld, m_addr_n);
            end
        end
    end

    task automatic step(input bit v, input logic [23:0] a, input bit we,
                        input logic [11:0] pd, input string tag);
        @(posedge clk);
        #1;
        ra_vld  = v;
        ra      = a;
        pfx_we  = we;
        pfx_din = pd;
        cur_tag = tag;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got running expected finished");
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        step(0, 24'h000000, 0, 12'h000, "R1");
        step(0, 24'h000000, 0, 12'h000, "R1");
        // R8: zero relocation value gives identity
        step(1, 24'h000ABC, 0, 12'h000, "R8");
        step(1, 24'h7A5123, 0, 12'h000, "R8");
        // R7: write and address on the new page in one cycle -> old value used
        step(1, 24'h123456, 1, 12'h123, "R7");
        step(1, 24'h123456, 0, 12'h000, "R3");
        step(1, 24'h000FED, 0, 12'h000, "R2");
        step(1, 24'h456789, 0, 12'h000, "R4");
        step(1, 24'h123000, 0, 12'h000, "R5");
        // R9: idle cycles hold the address
        step(0, 24'hFFFFFF, 0, 12'h000, "R9");
        step(0, 24'h000000, 0, 12'h000, "R9");
        // R7: write together with a page-zero access
        step(1, 24'h000111, 1, 12'h00A, "R7");
        step(1, 24'h000111, 0, 12'h000, "R2");
        // R10: narrow path, page 0xA reverses, page 0 forwards
        step(1, 24'h00A222, 0, 12'h000, "R10");
        step(1, 24'h000333, 0, 12'h000, "R10");
        step(1, 24'h00B444, 0, 12'h000, "R10");
        step(1, 24'h12A222, 0, 12'h000, "R4");
        // back to zero relocation value
        step(1, 24'h00A001, 1, 12'h000, "R7");
        step(1, 24'h00A001, 0, 12'h000, "R8");
        // mixed traffic
        for (int i = 0; i < 400; i++) begin
            logic [11:0] pg;
            logic [11:0] np;
            int sel;
            sel = int'($urandom_range(0, 3));
            np  = 12'($urandom);
            if (sel == 0)      pg = 12'h000;
            else if (sel == 1) pg = m_pfx;
            else               pg = 12'($urandom);
            step(($urandom_range(0, 4) != 0), {pg, 12'($urandom)},
                 ($urandom_range(0, 7) == 0), (sel == 3) ? {8'h00, np[3:0]} : np, "R2/R3/R4");
        end
        step(0, 24'h000000, 0, 12'h000, "R9");
        step(0, 24'h000000, 0, 12'h000, "R9");
        @(negedge clk);
        #1;
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule